// File: doc/BRIEF.md
# Shared-Pool Segment Allocator

This block manages the bookkeeping for a packet buffer that is cut into fixed-size segments. The buffer holds 128 KB for one physical port in one direction, with 256-byte segments, so there are 512 segments. The allocator hands segments out to up to 64 logical ports. Any freed segment goes back into one common pool and can later go to any port. No region of the buffer belongs to a particular port. The payload memory itself lives elsewhere. This block only decides which segment index a requester receives.

A client asks for a segment by raising `alloc_req` with a logical port number. One cycle later it sees either a grant with a segment index or a reject pulse. Returning a segment uses the segment index and the port that owned it. Software-visible settings are a per-port segment cap, written through a simple write strobe, and a pool threshold. From these the block raises a registered flow-control bit per port and one for the whole pool. After reset, an internal list of free indices fills itself in ascending order before the first allocation is accepted.

Top module: `seg_alloc_top`

## Requirements
- R1: After reset release the free list is loaded with indices 0 to NUM_SEGS-1, one per cycle. `init_done` rises exactly NUM_SEGS clock edges after reset release. Allocation requests seen before that are rejected. While reset is low, every output is 0.
- R2: Results are registered. A request sampled at edge k gives `alloc_grant` or `alloc_rej` (never both) after edge k. Granted indices leave the free list in first-in first-out order, so the first grants after reset are 0, 1, 2 and onwards.
- R3: A request made while the free list is empty is rejected, and no counter or list state changes.
- R4: A request for a port whose usage is at or above its cap is rejected, and no state changes. A cap of 0 blocks that port entirely.
- R5: Every cap resets to NUM_SEGS. A cap written with `cap_we` at edge k applies to requests sampled from edge k+1 on.
- R6: `port_fc[i]` is 1 when port i's usage is at or above its cap. It follows the counters with one cycle of lag: it reflects the counters as they stood after the previous edge.
- R7: `pool_fc` is 1 when the total number of allocated segments is at or above `pool_thresh`, with the same one-cycle lag as R6.
- R8: An allocate and a free in the same cycle are both processed. The head index is popped first, then the freed index is pushed at the tail. If both succeed, the total count is unchanged.
- R9: A free for a port whose usage is 0 is ignored and sets `free_err`. `free_err` then stays 1 until reset.
- R10: A freed index joins the common pool and may be granted next to any port, including a port other than its previous owner.
- R11: The number of allocated segments plus the free-list level always equals NUM_SEGS once initialisation is done, so the list never overflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_req | input | 1 | Request one segment |
| alloc_port | input | PORT_W | Logical port of the request |
| free_req | input | 1 | Return one segment |
| free_port | input | PORT_W | Logical port that owned the segment |
| free_seg | input | SEG_W | Index being returned |
| cap_we | input | 1 | Write strobe for a port cap |
| cap_port | input | PORT_W | Port whose cap is written |
| cap_val | input | CNT_W | New cap value |
| pool_thresh | input | CNT_W | Pool occupancy level for global flow control |
| init_done | output | 1 | Free list loaded |
| alloc_grant | output | 1 | Registered grant pulse |
| alloc_rej | output | 1 | Registered reject pulse |
| alloc_seg | output | SEG_W | Granted index, valid with `alloc_grant` |
| port_fc | output | NUM_PORTS | Per-port flow control |
| pool_fc | output | 1 | Pool flow control |
| free_err | output | 1 | Sticky bad-free flag |

## Verification
Suppose the free list's pointers or level go wrong. The index on `alloc_seg` then differs from the FIFO order predicted by the bench at the first grant that follows, and the point at which an empty pool starts rejecting moves. Suppose instead a per-port counter or the total goes wrong. This shows on `port_fc` or `pool_fc` one cycle later, and as a grant where a reject was due (or the reverse) on the next request to that port. The bench keeps its own queue and counters, so it catches each of these on the very cycle they become visible.

// File: rtl/seg_alloc_pkg.sv
package seg_alloc_pkg;

  // Level comparison used by every flow-control flag and admission check.
  function automatic logic reached(input int unsigned level, input int unsigned limit);
    return level >= limit;
  endfunction

  // Counter update for one cycle with optional increment and decrement.
  function automatic int unsigned adjust(input int unsigned value, input logic inc, input logic dec);
    int unsigned r;
    r = value;
    if (inc) r = r + 1;
    if (dec) r = r - 1;
    return r;
  endfunction

  // Ring pointer advance for a list of arbitrary depth.
  function automatic int unsigned ring_next(input int unsigned ptr, input int unsigned depth);
    return (ptr == depth - 1) ? 0 : ptr + 1;
  endfunction

endpackage

// File: rtl/seg_free_list.sv
module seg_free_list
  import seg_alloc_pkg::*;
#(
  parameter int NUM_SEGS = 512,
  parameter int SEG_W    = $clog2(NUM_SEGS),
  parameter int CNT_W    = $clog2(NUM_SEGS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pop,
  input  logic             push,
  input  logic [SEG_W-1:0] push_seg,
  output logic [SEG_W-1:0] head_seg,
  output logic [CNT_W-1:0] level,
  output logic             ready
);

  logic [SEG_W-1:0] mem [NUM_SEGS];
  logic [SEG_W-1:0] rd_ptr, wr_ptr, fill_idx;
  logic [CNT_W-1:0] level_q;
  logic             ready_q;
  wire              fill_last = (fill_idx == SEG_W'(NUM_SEGS - 1));

  always_ff @(posedge clk) begin
    if (!ready_q) mem[fill_idx] <= fill_idx;
    else if (push) mem[wr_ptr] <= push_seg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr   <= '0;
      wr_ptr   <= '0;
      fill_idx <= '0;
      level_q  <= '0;
      ready_q  <= 1'b0;
    end else if (!ready_q) begin
      fill_idx <= SEG_W'(ring_next(32'(fill_idx), NUM_SEGS));
      if (fill_last) begin
        ready_q <= 1'b1;
        level_q <= CNT_W'(NUM_SEGS);
      end
    end else begin
      if (pop)  rd_ptr <= SEG_W'(ring_next(32'(rd_ptr), NUM_SEGS));
      if (push) wr_ptr <= SEG_W'(ring_next(32'(wr_ptr), NUM_SEGS));
      level_q <= CNT_W'(adjust(32'(level_q), push, pop));
    end
  end

  assign head_seg = mem[rd_ptr];
  assign level    = level_q;
  assign ready    = ready_q;

  p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (ready_q && level_q != '0));
  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |-> (level_q < CNT_W'(NUM_SEGS)));

endmodule

// File: rtl/seg_port_ledger.sv
module seg_port_ledger
  import seg_alloc_pkg::*;
#(
  parameter int NUM_PORTS = 64,
  parameter int PORT_W    = $clog2(NUM_PORTS),
  parameter int CNT_W     = 10,
  parameter int CAP_RST   = 512
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cap_we,
  input  logic [PORT_W-1:0]    cap_port,
  input  logic [CNT_W-1:0]     cap_val,
  input  logic [PORT_W-1:0]    alloc_port,
  input  logic [PORT_W-1:0]    free_port,
  input  logic                 inc,
  input  logic                 dec,
  output logic                 alloc_room,
  output logic                 free_held,
  output logic [NUM_PORTS-1:0] port_fc
);

  logic [CNT_W-1:0] usage_q [NUM_PORTS];
  logic [CNT_W-1:0] cap_q   [NUM_PORTS];

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    wire hit_a = inc    && (alloc_port == PORT_W'(i));
    wire hit_f = dec    && (free_port  == PORT_W'(i));
    wire hit_c = cap_we && (cap_port   == PORT_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        usage_q[i] <= '0;
        cap_q[i]   <= CNT_W'(CAP_RST);
        port_fc[i] <= 1'b0;
      end else begin
        usage_q[i] <= CNT_W'(adjust(32'(usage_q[i]), hit_a, hit_f));
        if (hit_c) cap_q[i] <= cap_val;
        port_fc[i] <= reached(32'(usage_q[i]), 32'(cap_q[i]));
      end
    end
  end

  assign alloc_room = !reached(32'(usage_q[alloc_port]), 32'(cap_q[alloc_port]));
  assign free_held  = (usage_q[free_port] != '0);

  p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> (usage_q[free_port] != '0));
  p_cap_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> (usage_q[alloc_port] < cap_q[alloc_port]));

endmodule

// File: rtl/seg_alloc_top.sv
module seg_alloc_top
  import seg_alloc_pkg::*;
#(
  parameter int NUM_SEGS  = 512,
  parameter int NUM_PORTS = 64,
  parameter int SEG_W     = $clog2(NUM_SEGS),
  parameter int PORT_W    = $clog2(NUM_PORTS),
  parameter int CNT_W     = $clog2(NUM_SEGS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 alloc_req,
  input  logic [PORT_W-1:0]    alloc_port,
  input  logic                 free_req,
  input  logic [PORT_W-1:0]    free_port,
  input  logic [SEG_W-1:0]     free_seg,
  input  logic                 cap_we,
  input  logic [PORT_W-1:0]    cap_port,
  input  logic [CNT_W-1:0]     cap_val,
  input  logic [CNT_W-1:0]     pool_thresh,
  output logic                 init_done,
  output logic                 alloc_grant,
  output logic                 alloc_rej,
  output logic [SEG_W-1:0]     alloc_seg,
  output logic [NUM_PORTS-1:0] port_fc,
  output logic                 pool_fc,
  output logic                 free_err
);

  // Named internal events for the assertions.
  logic             list_ready, port_room, port_held;
  logic [SEG_W-1:0] head_seg;
  logic [CNT_W-1:0] list_level;
  logic [CNT_W-1:0] total_q;
  logic             alloc_ok, free_ok, free_bad;

  assign alloc_ok = alloc_req && list_ready && (list_level != '0) && port_room;
  assign free_ok  = free_req && port_held;
  assign free_bad = free_req && !port_held;

  seg_free_list #(.NUM_SEGS(NUM_SEGS), .SEG_W(SEG_W), .CNT_W(CNT_W)) u_list (
    .clk(clk), .rst_n(rst_n), .pop(alloc_ok), .push(free_ok), .push_seg(free_seg),
    .head_seg(head_seg), .level(list_level), .ready(list_ready)
  );

  seg_port_ledger #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .CNT_W(CNT_W),
                    .CAP_RST(NUM_SEGS)) u_ledger (
    .clk(clk), .rst_n(rst_n), .cap_we(cap_we), .cap_port(cap_port), .cap_val(cap_val),
    .alloc_port(alloc_port), .free_port(free_port), .inc(alloc_ok), .dec(free_ok),
    .alloc_room(port_room), .free_held(port_held), .port_fc(port_fc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total_q     <= '0;
      pool_fc     <= 1'b0;
      free_err    <= 1'b0;
      alloc_grant <= 1'b0;
      alloc_rej   <= 1'b0;
      alloc_seg   <= '0;
    end else begin
      total_q     <= CNT_W'(adjust(32'(total_q), alloc_ok, free_ok));
      pool_fc     <= reached(32'(total_q), 32'(pool_thresh));
      free_err    <= free_err || free_bad;
      alloc_grant <= alloc_ok;
      alloc_rej   <= alloc_req && !alloc_ok;
      if (alloc_ok) alloc_seg <= head_seg;
    end
  end

  assign init_done = list_ready;

  p_one_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(alloc_grant && alloc_rej));
  p_conserve_r11: assert property (@(posedge clk) disable iff (!rst_n)
    list_ready |-> (32'(total_q) + 32'(list_level) == NUM_SEGS));
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    free_err |=> free_err);
  p_no_early_grant_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !list_ready |-> !alloc_ok);

endmodule

// File: tb/sim_seg_alloc_top.sv
module sim_seg_alloc_top;
  localparam int N  = 16;
  localparam int P  = 4;
  localparam int SW = $clog2(N);
  localparam int PW = $clog2(P);
  localparam int CW = $clog2(N + 1);
  localparam int THR = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic alloc_req = 0, free_req = 0, cap_we = 0;
  logic [PW-1:0] alloc_port = '0, free_port = '0, cap_port = '0;
  logic [SW-1:0] free_seg = '0;
  logic [CW-1:0] cap_val = '0, pool_thresh = CW'(THR);
  logic init_done, alloc_grant, alloc_rej, pool_fc, free_err;
  logic [SW-1:0] alloc_seg;
  logic [P-1:0] port_fc;

  seg_alloc_top #(.NUM_SEGS(N), .NUM_PORTS(P)) u0 (
    .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_port(alloc_port),
    .free_req(free_req), .free_port(free_port), .free_seg(free_seg),
    .cap_we(cap_we), .cap_port(cap_port), .cap_val(cap_val), .pool_thresh(pool_thresh),
    .init_done(init_done), .alloc_grant(alloc_grant), .alloc_rej(alloc_rej),
    .alloc_seg(alloc_seg), .port_fc(port_fc), .pool_fc(pool_fc), .free_err(free_err));

  always #10 clk = ~clk;

  int tests = 0, fails = 0;
  int q[$];
  int hs[$];
  int hp[$];
  int use_m[P];
  int cap_m[P];
  int total_m = 0, edges = 0;
  bit err_m = 0;
  bit finished = 0;

  task automatic chk(input string rq, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d time=%0t", rq, act, exp, $time);
    end
  endtask

  // One clock: inputs driven now (after a negedge), results checked just after the edge.
  task automatic step(input bit ar, input int ap, input bit fr, input int fp, input int fs,
                      input bit cw, input int cp, input int cv, input string tag);
    bit ready_m, ok_a, ok_f;
    int exp_seg, exp_fc;
    ready_m = (edges >= N);
    ok_a = ar && ready_m && q.size() > 0 && use_m[ap] < cap_m[ap];
    ok_f = fr && use_m[fp] != 0;
    exp_seg = ok_a ? q[0] : 0;
    exp_fc = 0;
    for (int i = 0; i < P; i++) if (use_m[i] >= cap_m[i]) exp_fc |= (1 << i);
    alloc_req = ar; alloc_port = PW'(ap);
    free_req = fr; free_port = PW'(fp); free_seg = SW'(fs);
    cap_we = cw; cap_port = PW'(cp); cap_val = CW'(cv);
    @(posedge clk); #1;
    edges++;
    chk({tag, " R2 grant"}, int'(alloc_grant), int'(ok_a));
    chk({tag, " R3/R4 reject"}, int'(alloc_rej), int'(ar && !ok_a));
    if (ok_a) chk({tag, " R2 seg order"}, int'(alloc_seg), exp_seg);
    chk({tag, " R6 port_fc"}, int'(port_fc), exp_fc);
    chk({tag, " R7 pool_fc"}, int'(pool_fc), int'(total_m >= THR));
    chk({tag, " R9 free_err"}, int'(free_err), int'(err_m || (fr && !ok_f)));
    chk({tag, " R1 init_done"}, int'(init_done), int'(edges >= N));
    if (ok_a) begin
      void'(q.pop_front());
      use_m[ap]++; total_m++;
      hs.push_back(exp_seg); hp.push_back(ap);
    end
    if (ok_f) begin
      q.push_back(fs);
      use_m[fp]--; total_m--;
    end
    if (fr && !ok_f) err_m = 1;
    if (cw) cap_m[cp] = cv;
    @(negedge clk);
    alloc_req = 0; free_req = 0; cap_we = 0;
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  // Return the held segment at position k of the bench's ownership list.
  task automatic give_back(input int k, input bit ar, input int ap, input string tag);
    int s, p;
    s = hs[k]; p = hp[k];
    hs.delete(k); hp.delete(k);
    step(ar, ap, 1, p, s, 0, 0, 0, tag);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < P; i++) begin use_m[i] = 0; cap_m[i] = N; end
    repeat (3) @(posedge clk);
    #1;
    // R1: everything low while reset is held
    chk("R1 reset grant", int'(alloc_grant), 0);
    chk("R1 reset rej", int'(alloc_rej), 0);
    chk("R1 reset fc", int'(port_fc), 0);
    chk("R1 reset err", int'(free_err), 0);
    chk("R1 reset init_done", int'(init_done), 0);
    @(negedge clk); rst_n = 1;
    // R1: request during fill is rejected
    step(1, 0, 0, 0, 0, 0, 0, 0, "R1 early alloc");
    while (edges < N + 1) idle("R1 fill");
    for (int i = 0; i < N; i++) q.push_back(i);
    // R5: caps written, take effect next cycle
    step(1, 2, 0, 0, 0, 1, 2, 0, "R5 old cap used");
    step(0, 0, 0, 0, 0, 1, 0, 3, "R5 cap p0");
    step(0, 0, 0, 0, 0, 1, 3, 5, "R5 cap p3");
    // R4: cap enforcement
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0, 0, 0, 0, "R4 p0 cap3");
    step(1, 2, 0, 0, 0, 0, 0, 0, "R4 p2 cap0");
    step(1, 2, 0, 0, 0, 0, 0, 0, "R4 p2 still blocked");
    // R3: drain the pool through port 1
    while (q.size() > 0) step(1, 1, 0, 0, 0, 0, 0, 0, "R3 drain p1");
    step(1, 1, 0, 0, 0, 0, 0, 0, "R3 empty");
    // R8/R10: free while empty with alloc same cycle, then reuse by another port
    give_back(0, 1, 3, "R8 empty pop+push");
    step(1, 3, 0, 0, 0, 0, 0, 0, "R10 reuse by p3");
    give_back(0, 1, 3, "R8 pop then push");
    idle("R8 settle");
    // R9: free on port with zero usage is ignored
    step(0, 0, 1, 2, 7, 0, 0, 0, "R9 bad free");
    idle("R9 sticky");
    step(1, 3, 0, 0, 0, 0, 0, 0, "R9 state unchanged");
    // Mixed sweep
    for (int it = 0; it < 1500; it++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 5) step(0, 0, 0, 0, 0, 1, int'($urandom_range(0, P - 1)),
                      int'($urandom_range(0, N)), "R5 sweep cap");
      else if (r < 8) step(1, int'($urandom_range(0, P - 1)), 1,
                           int'($urandom_range(0, P - 1)), int'($urandom_range(0, N - 1)),
                           0, 0, 0, "R9 sweep mixed");
      else if (r < 50 && hs.size() > 0)
        give_back(int'($urandom_range(0, hs.size() - 1)), r < 30,
                  int'($urandom_range(0, P - 1)), "R8 sweep free");
      else step(1, int'($urandom_range(0, P - 1)), 0, 0, 0, 0, 0, 0, "R2 sweep alloc");
    end
    while (hs.size() > 0) give_back(0, 0, 0, "R11 return all");
    idle("R7 empty pool");
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule